// File: doc/BRIEF.md
# Strided Vector Element Address Generator

This block turns one strided vector memory instruction into a stream of per-element memory requests. A start pulse loads a byte base address, a signed 32-bit byte stride, a vector length, an element size (4-byte or 8-byte) and an optional element mask with a selectable match polarity. Afterwards the block presents one request per active element, in ascending index order. Each request carries the element index, the byte address `base + index*stride` (modulo 2^32) and a store/load flag, and it is exchanged on a valid/ready handshake.

Any active element whose address is not a multiple of the element size stops issue before that element is requested. The block then signals completion with an error and reports the index of the offending element. For a store with a zero stride every element targets the same location, and only the highest-numbered element may leave its value there. In that case the block sends only that one write and drops the others. The memory system, address translation and the vector register file sit outside the block.

Top module: `vec_stride_agu`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `req_valid` and `done` are low.
- R2: The request for element i carries the address `base + i*stride` modulo 2^32, where the stride is a two's-complement byte count that may be positive, negative or zero. Requests leave in strictly ascending index order, and a requester that holds `req_ready` high gets one request per cycle.
- R3: With `mask_en` high, element i is active only when `mask[i]` equals `mask_pol`. With `mask_en` low, every element below the length is active. Inactive elements are never requested and never fault.
- R4: `done` is a one-cycle pulse. It rises the cycle after the last accepted request, or two cycles after the start pulse when there is nothing to issue (length 0 or no active element). In these cases `done_err` is 0.
- R5: A `vec_len` above 64 is treated as 64.
- R6: For a store (`is_store`=1) with stride 0, only the highest active element is requested. A load with stride 0 requests every active element at the same address.
- R7: An element is misaligned when `elem_quad`=0 (4-byte) and address bits [1:0] are nonzero, or when `elem_quad`=1 (8-byte) and address bits [2:0] are nonzero. The first active misaligned element is not requested, and issue stops. `done` then pulses with `done_err`=1 and `fault_idx` set to that element's index. The active elements before it are requested normally.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_idx` and `req_addr` hold steady.
- R9: `req_store` equals the `is_store` captured at start. A `start` pulse while `busy` is high is ignored and does not change the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a job; accepted only while not busy |
| is_store | input | 1 | 1 = store job, 0 = load job |
| elem_quad | input | 1 | 0 = 4-byte elements, 1 = 8-byte elements |
| base_addr | input | 32 | Byte address of element 0 |
| stride | input | 32 | Signed byte distance between consecutive elements |
| vec_len | input | 7 | Number of elements, clamped to 64 |
| mask_en | input | 1 | Enable per-element masking |
| mask_pol | input | 1 | Mask bit value that marks an element active |
| mask | input | 64 | Per-element mask bits |
| busy | output | 1 | A job is in progress |
| req_valid | output | 1 | A request is offered |
| req_ready | input | 1 | The memory side accepts the request |
| req_idx | output | 6 | Element index of the request |
| req_addr | output | 32 | Byte address of the request |
| req_store | output | 1 | Request is a write |
| done | output | 1 | One-cycle job completion pulse |
| done_err | output | 1 | Completed job stopped on a misaligned element |
| fault_idx | output | 6 | Index of the misaligned element |

## Verification
The bench attacks negative strides that wrap the address, masks of either polarity that skip elements, zero and oversized lengths, and zero-stride stores. A wrong design here would emit wrapped or out-of-order addresses, leak masked elements, issue elements past 64, or let an earlier element's write reach memory last. Misalignment cases include a fault on element 0, a fault midway through the vector, and a misaligned element hidden by the mask. A design that got these wrong would raise a false fault, report the wrong index, or still emit the bad request. Random back-pressure and a start pulse during a busy job test whether a stalled request changes under the requester or a running job gets clobbered.

// File: rtl/vec_agu_pkg.sv
// Shared types and helpers for the strided vector address generator.
// Assumes byte addressing and element sizes of 4 or 8 bytes.
package vec_agu_pkg;

    typedef enum logic {
        AGU_IDLE = 1'b0,
        AGU_RUN  = 1'b1
    } agu_state_e;

    // True when the low address bits violate natural alignment for the element size.
    function automatic logic addr_misaligned(input logic quad, input logic [2:0] lo);
        return quad ? (lo != 3'b000) : (lo[1:0] != 2'b00);
    endfunction

endpackage

// File: rtl/vec_agu_select.sv
// Builds the set of active elements for a new job from length, mask and mode.
// Assumes len is already clamped to N. With last_only set, only the highest
// active element survives (zero-stride store rule).
module vec_agu_select #(
    parameter int N     = 64,
    parameter int LEN_W = 7,
    parameter int IDX_W = 6
) (
    input  logic [LEN_W-1:0] len,
    input  logic             mask_en,
    input  logic             mask_pol,
    input  logic [N-1:0]     mask,
    input  logic             last_only,
    output logic [N-1:0]     act
);

    logic [N-1:0] raw;
    logic [N-1:0] top_only;
    logic [IDX_W-1:0] hi_idx;
    logic             any_act;

    // Per-element qualification: inside the length and matching the mask.
    for (genvar j = 0; j < N; j++) begin : g_qual
        assign raw[j] = (LEN_W'(j) < len) && (!mask_en || (mask[j] == mask_pol));
    end

    // Locate the highest active element.
    always_comb begin
        hi_idx  = '0;
        any_act = 1'b0;
        for (int j = 0; j < N; j++) begin
            if (raw[j]) begin
                hi_idx  = IDX_W'(j);
                any_act = 1'b1;
            end
        end
    end

    // One-hot of the highest active element, empty when none is active.
    always_comb begin
        top_only         = '0;
        top_only[hi_idx] = any_act;
    end

    assign act = last_only ? top_only : raw;

endmodule

// File: rtl/vec_agu_pick.sv
// Finds the lowest active element at or above a starting position.
// Assumes from may equal N, meaning the scan is past the end.
module vec_agu_pick #(
    parameter int N     = 64,
    parameter int LEN_W = 7,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     act,
    input  logic [LEN_W-1:0] from,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [N-1:0] elig;

    // An element is eligible when active and not yet passed.
    for (genvar j = 0; j < N; j++) begin : g_elig
        assign elig[j] = act[j] && (LEN_W'(j) >= from);
    end

    // Priority encoder: lowest eligible index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (elig[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/vec_agu_addr.sv
// Computes base + idx*stride (modulo 2^ADDR_W) and checks natural alignment.
// Assumes two's-complement stride; wraparound is intended.
module vec_agu_addr
    import vec_agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [IDX_W-1:0]  idx,
    input  logic              quad,
    output logic [ADDR_W-1:0] addr,
    output logic              misaligned
);

    logic [ADDR_W-1:0] offset;

    // Scaled offset of the element; modular product covers negative strides.
    always_comb offset = stride * {{(ADDR_W-IDX_W){1'b0}}, idx};

    assign addr       = base + offset;
    assign misaligned = addr_misaligned(quad, addr[2:0]);

endmodule

// File: rtl/vec_stride_agu.sv
// Strided vector element address generator. A start pulse captures the job;
// active elements are then requested in ascending order on a valid/ready
// handshake, one per cycle. A misaligned active element stops issue and is
// reported with done_err. Assumes MAX_LEN is a power of two.
module vec_stride_agu
    import vec_agu_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(MAX_LEN),
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_store,
    input  logic              elem_quad,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [LEN_W-1:0]  vec_len,
    input  logic              mask_en,
    input  logic              mask_pol,
    input  logic [MAX_LEN-1:0] mask,
    output logic              busy,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [IDX_W-1:0]  req_idx,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_store,
    output logic              done,
    output logic              done_err,
    output logic [IDX_W-1:0]  fault_idx
);

    agu_state_e        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stride_q;
    logic              quad_q;
    logic              store_q;
    logic              last_q;
    logic [MAX_LEN-1:0] act_q;
    logic [LEN_W-1:0]  cur_q;
    logic              done_q;
    logic              err_q;
    logic [IDX_W-1:0]  fidx_q;

    logic [LEN_W-1:0]  len_clamped;
    logic              last_only;
    logic [MAX_LEN-1:0] act_new;
    logic              found;
    logic [IDX_W-1:0]  pick_idx;
    logic [ADDR_W-1:0] elem_addr;
    logic              elem_mis;
    logic              run;
    logic              accept;
    logic              fire;
    logic              finish;

    // Clamp requested length to the supported maximum.
    always_comb len_clamped = (vec_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : vec_len;

    // Zero-stride stores keep only the highest active element.
    always_comb last_only = is_store && (stride == '0);

    vec_agu_select #(.N(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_select (
        .len       (len_clamped),
        .mask_en   (mask_en),
        .mask_pol  (mask_pol),
        .mask      (mask),
        .last_only (last_only),
        .act       (act_new)
    );

    vec_agu_pick #(.N(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_pick (
        .act   (act_q),
        .from  (cur_q),
        .found (found),
        .idx   (pick_idx)
    );

    vec_agu_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .base       (base_q),
        .stride     (stride_q),
        .idx        (pick_idx),
        .quad       (quad_q),
        .addr       (elem_addr),
        .misaligned (elem_mis)
    );

    // Handshake and completion conditions.
    always_comb begin
        run    = (state_q == AGU_RUN);
        accept = (state_q == AGU_IDLE) && start;
        fire   = run && found && !elem_mis && req_ready;
        finish = run && (!found || elem_mis);
    end

    // Job state: capture on start, advance on handshake, end on exhaustion or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= AGU_IDLE;
            base_q   <= '0;
            stride_q <= '0;
            quad_q   <= 1'b0;
            store_q  <= 1'b0;
            last_q   <= 1'b0;
            act_q    <= '0;
            cur_q    <= '0;
        end else if (accept) begin
            state_q  <= AGU_RUN;
            base_q   <= base_addr;
            stride_q <= stride;
            quad_q   <= elem_quad;
            store_q  <= is_store;
            last_q   <= last_only;
            act_q    <= act_new;
            cur_q    <= '0;
        end else if (finish) begin
            state_q  <= AGU_IDLE;
        end else if (fire) begin
            cur_q    <= LEN_W'(pick_idx) + LEN_W'(1);
        end
    end

    // Completion pulse and sticky error report of the last finished job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            fidx_q <= '0;
        end else begin
            done_q <= finish;
            if (finish) begin
                err_q  <= found && elem_mis;
                fidx_q <= (found && elem_mis) ? pick_idx : '0;
            end
        end
    end

    assign busy      = run;
    assign req_valid = run && found && !elem_mis;
    assign req_idx   = pick_idx;
    assign req_addr  = elem_addr;
    assign req_store = store_q;
    assign done      = done_q;
    assign done_err  = err_q;
    assign fault_idx = fidx_q;

    // Offered requests never change while stalled.
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_idx) && $stable(req_addr));

    // Accepted requests are followed only by higher indices.
    p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid || (req_idx > $past(req_idx)));

    // No request ever leaves misaligned for its element size.
    p_aligned_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (quad_q ? (req_addr[2:0] == 3'b000) : (req_addr[1:0] == 2'b00)));

    // Nothing is offered while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    // Completion lasts exactly one cycle.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A zero-stride store issues a single write and then stops.
    p_single_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_q && req_valid && req_ready |=> !req_valid);

    // The store flag stays fixed for the whole job.
    p_store_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(req_store));

endmodule

// File: tb/vec_stride_agu_test.sv
module vec_stride_agu_test;

    localparam int CLK_PERIOD = 10;
    localparam int ML = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_store = 1'b0;
    logic        elem_quad = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] stride = '0;
    logic [6:0]  vec_len = '0;
    logic        mask_en = 1'b0;
    logic        mask_pol = 1'b0;
    logic [63:0] mask = '0;
    logic        req_ready = 1'b0;
    logic        busy, req_valid, req_store, done, done_err;
    logic [5:0]  req_idx, fault_idx;
    logic [31:0] req_addr;

    int checks = 0;
    int failures = 0;

    int          exp_idx[ML];
    logic [31:0] exp_addr[ML];
    int          exp_n;
    bit          exp_err;
    int          exp_fidx;

    vec_stride_agu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .elem_quad(elem_quad), .base_addr(base_addr), .stride(stride),
        .vec_len(vec_len), .mask_en(mask_en), .mask_pol(mask_pol), .mask(mask),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
        .req_idx(req_idx), .req_addr(req_addr), .req_store(req_store),
        .done(done), .done_err(done_err), .fault_idx(fault_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Reference model built from the requirements.
    task automatic build_exp(input bit st, input bit q, input logic [31:0] b,
                             input logic [31:0] s, input int len, input bit men,
                             input bit mpol, input logic [63:0] m);
        bit act[ML];
        int lim;
        int hi;
        logic [31:0] a;
        lim = (len > ML) ? ML : len;
        hi = -1;
        for (int i = 0; i < ML; i++) begin
            act[i] = (i < lim) && (!men || (m[i] == mpol));
            if (act[i]) hi = i;
        end
        if (st && s == 32'd0)
            for (int i = 0; i < ML; i++) act[i] = (i == hi);
        exp_n = 0; exp_err = 0; exp_fidx = 0;
        for (int i = 0; i < ML; i++) begin
            if (act[i]) begin
                a = b + s * 32'(i);
                if (q ? (a[2:0] != 0) : (a[1:0] != 0)) begin
                    exp_err = 1; exp_fidx = i;
                    break;
                end
                exp_idx[exp_n] = i;
                exp_addr[exp_n] = a;
                exp_n++;
            end
        end
    endtask

    task automatic run_job(input string tag, input bit st, input bit q,
                           input logic [31:0] b, input logic [31:0] s, input int len,
                           input bit men, input bit mpol, input logic [63:0] m,
                           input int ready_pct, input bit poke, input bit timed);
        int k;
        bit seen_done;
        bit stalled;
        logic [5:0] p_idx;
        logic [31:0] p_addr;
        build_exp(st, q, b, s, len, men, mpol, m);
        @(negedge clk);
        is_store = st; elem_quad = q; base_addr = b; stride = s;
        vec_len = 7'(len); mask_en = men; mask_pol = mpol; mask = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; seen_done = 0; stalled = 0; p_idx = '0; p_addr = '0;
        for (int cyc = 1; cyc <= 2000; cyc++) begin
            req_ready = (($urandom % 100) < ready_pct);
            if (poke) begin
                start = (cyc == 3);
                if (cyc == 3) begin
                    is_store = ~st; base_addr = b + 32'h40; stride = 32'd0; vec_len = 7'd1;
                end
            end
            if (cyc == 1) check(busy == 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
            if (req_valid) begin
                if (stalled)
                    check(req_idx == p_idx && req_addr == p_addr, "R8", "stall hold",
                          {26'd0, req_idx, req_addr}, {26'd0, p_idx, p_addr});
                if (req_ready) begin
                    if (k < exp_n) begin
                        check(int'(req_idx) == exp_idx[k], tag, "req index",
                              64'(req_idx), 64'(exp_idx[k]));
                        check(req_addr == exp_addr[k], tag, "req address",
                              64'(req_addr), 64'(exp_addr[k]));
                    end else begin
                        check(1'b0, tag, "extra request index", 64'(req_idx), 64'(ML));
                    end
                    check(req_store == st, "R9", "store flag", 64'(req_store), 64'(st));
                    k++;
                end
            end
            stalled = req_valid && !req_ready;
            p_idx = req_idx; p_addr = req_addr;
            if (done) begin
                seen_done = 1;
                check(k == exp_n, tag, "request count", 64'(k), 64'(exp_n));
                check(done_err == exp_err, "R7", "done_err", 64'(done_err), 64'(exp_err));
                if (exp_err)
                    check(int'(fault_idx) == exp_fidx, "R7", "fault_idx",
                          64'(fault_idx), 64'(exp_fidx));
                if (timed)
                    check(cyc == 2, "R4", "empty job done cycle", 64'(cyc), 64'd2);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (!seen_done) check(1'b0, tag, "job never completed", 64'd0, 64'd1);
        @(negedge clk);
        check(done == 1'b0, "R4", "done single pulse", 64'(done), 64'd0);
        req_ready = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(busy == 0 && req_valid == 0 && done == 0, "R1", "reset outputs",
              {61'd0, busy, req_valid, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && req_valid == 0, "R1", "idle after reset",
              {62'd0, busy, req_valid}, 64'd0);

        // R2: contiguous, negative and wrapping strides
        run_job("R2", 0, 0, 32'h1000, 32'd4, 8, 0, 0, 64'd0, 100, 0, 0);
        run_job("R2", 1, 1, 32'h2000, -32'sd8, 5, 0, 0, 64'd0, 50, 0, 0);
        run_job("R2", 0, 1, 32'h10, -32'sd16, 6, 0, 0, 64'd0, 70, 0, 0);
        // R3: both mask polarities
        run_job("R3", 0, 0, 32'h400, 32'd12, 16, 1, 1, 64'h0000_0000_0000_A5C3, 100, 0, 0);
        run_job("R3", 1, 0, 32'h400, 32'd12, 16, 1, 0, 64'h0000_0000_0000_A5C3, 60, 0, 0);
        // R4: empty jobs
        run_job("R4", 0, 0, 32'h800, 32'd4, 0, 0, 0, 64'd0, 100, 0, 1);
        run_job("R4", 1, 1, 32'h800, 32'd8, 10, 1, 1, 64'd0, 100, 0, 1);
        // R5: oversized length
        run_job("R5", 0, 0, 32'h3000, 32'd4, 100, 0, 0, 64'd0, 100, 0, 0);
        // R6: zero-stride store and load
        run_job("R6", 1, 0, 32'h500, 32'd0, 20, 1, 1, 64'h0000_0000_0002_0811, 100, 0, 0);
        run_job("R6", 1, 1, 32'h508, 32'd0, 64, 0, 0, 64'd0, 40, 0, 0);
        run_job("R6", 0, 0, 32'h500, 32'd0, 4, 0, 0, 64'd0, 100, 0, 0);
        // R7: faults midway, at element 0, and masked-out misalignment
        run_job("R7", 0, 1, 32'h100, 32'd12, 6, 0, 0, 64'd0, 100, 0, 0);
        run_job("R7", 1, 0, 32'h2, 32'd4, 6, 0, 0, 64'd0, 100, 0, 0);
        run_job("R7", 0, 0, 32'h0, 32'd2, 12, 1, 1, 64'h0000_0000_0000_0555, 100, 0, 0);
        run_job("R7", 1, 1, 32'h3, 32'd0, 3, 0, 0, 64'd0, 100, 0, 0);
        // R8/R9: heavy back-pressure and a start pulse during a busy job
        run_job("R8", 0, 0, 32'h6000, 32'd4, 20, 0, 0, 64'd0, 30, 1, 0);

        // Constrained random jobs
        for (int n = 0; n < 60; n++) begin
            bit q;
            int sz;
            logic [31:0] b;
            logic [31:0] s;
            q = $urandom % 2;
            sz = q ? 8 : 4;
            b = $urandom & 32'hFFFF_FFF8;
            s = 32'(($urandom % 33) - 16) * 32'(sz);
            if (($urandom % 8) == 0) s = s + 32'($urandom % 4);
            if (($urandom % 10) == 0) b = b + 32'($urandom % 8);
            run_job("R2", $urandom % 2, q, b, s, $urandom % 80,
                    $urandom % 2, $urandom % 2, {$urandom, $urandom},
                    20 + ($urandom % 81), 0, 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule